// File: doc/BRIEF.md
# Voice Parameter Write Decoder

This block sits behind the register port of a 64-voice sample-playback engine. It receives plain register writes and turns them into stored playback parameters for each voice: where the sample starts, whether and where it loops, the sample encoding, the pitch word, the pan position and the volume level. Writes to a voice's configuration word can also start or stop that voice. The block reports a start or stop as a pulse on a shared pair of key outputs, together with the number of the voice concerned.

Two address windows each cover 32 voices. A single select input chooses the window, and each voice takes a 128-byte slot inside it. The playback engine reads the stored state of one voice at a time through an indexed read port. The block stores the pan and volume values in the form the mixer uses: pan is folded and volume is run through an audio-taper curve. Envelope handling, sample fetch and mixing are done elsewhere.

Top module: `voice_reg_decoder`

## Requirements
- R1: The target voice of a write is offset[11:7] plus 32 when winSel is 1. The slot number of a voice is offset[11:7], and the register inside the slot is selected by offset[6:0].
- R2: Only wrData[15:0] is used. Bits 31:16 of the data word have no effect on any stored field or on any key pulse.
- R3: A write to register 0x00 stores data bits 4:0 as start-address bits 20:16 and data bit 9 as the loop enable. A write to 0x04 stores start-address bits 15:0. Each of these writes leaves the other part of the start address unchanged.
- R4: Data bits 8:7 of a 0x00 write set rdFormat. A field value of 0 gives 0 (16-bit PCM), 1 gives 1 (8-bit PCM), and both 2 and 3 give 2 (ADPCM).
- R5: Data bits 15:14 of a 0x00 write form a key command. A value of 3 raises keyOn and a value of 2 raises keyOff, for exactly the one cycle after the write edge, with keyVoice set to the written voice. Values 0 and 1 raise neither pulse. keyOn and keyOff are never high together.
- R6: Register 0x08 stores the 16-bit loop start, 0x0C the 16-bit loop end, and 0x18 the 16-bit pitch word.
- R7: Register 0x24 stores the pan from data bits 4:0. A value p of 15 or less is stored as 15-p, and a value from 16 to 31 is stored unchanged.
- R8: Register 0x28 stores a volume derived from data bits 7:0 (v) by the curve (v*(v+1))>>8. This maps 0 to 0 and 255 to 255.
- R9: Writes to 0x10, 0x14, 0x1C, 0x20 or any other offset not listed above change no stored field and raise no key pulse.
- R10: After reset every stored field of every voice reads 0, and keyOn and keyOff are low.
- R11: The read port is combinational on rdVoice. A written value is visible there from the clock edge that takes the write onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| winSel | input | 1 | Window select (0: voices 0-31, 1: voices 32-63) |
| wrOffset | input | 12 | Byte offset inside the window |
| wrData | input | 32 | Write data |
| rdVoice | input | 6 | Voice selected on the read port |
| rdStartAddr | output | 21 | Sample start address |
| rdLoopEn | output | 1 | Loop enable |
| rdFormat | output | 2 | Sample encoding (0 16-bit, 1 8-bit, 2 ADPCM) |
| rdLoopStart | output | 16 | Loop start point |
| rdLoopEnd | output | 16 | Loop end point |
| rdPitch | output | 16 | Pitch word |
| rdPan | output | 5 | Folded pan position |
| rdVolume | output | 8 | Volume after the curve |
| keyOn | output | 1 | One-cycle start pulse |
| keyOff | output | 1 | One-cycle stop pulse |
| keyVoice | output | 6 | Voice number carried by the key pulse |

## Verification
A single configuration write does two things in the same cycle: it updates the start-address high bits, the loop enable and the format of the voice, and it raises a key pulse. The bench provokes this with one write that carries a key-on command together with new address and loop bits to a voice in the upper window. In the cycle after that write edge, it checks the pulse, its voice number and the new field values all at the same sample, and then checks one cycle later that the pulse has dropped.

// File: rtl/voice_reg_pkg.sv
package voice_reg_pkg;
  localparam int VOICE_W = 6;
  localparam int HALF_W  = 16;

  typedef struct packed {
    logic                cfg;
    logic                addrLo;
    logic                loopStart;
    logic                loopEnd;
    logic                pitch;
    logic                pan;
    logic                vol;
    logic [VOICE_W-1:0]  voice;
    logic [HALF_W-1:0]   data;
  } wr_strobe_t;

  localparam logic [1:0] FMT_PCM16 = 2'd0;
  localparam logic [1:0] FMT_PCM8  = 2'd1;
  localparam logic [1:0] FMT_ADPCM = 2'd2;
endpackage

// File: rtl/voice_reg_ctrl.sv
module voice_reg_ctrl
  import voice_reg_pkg::*;
#(
  parameter int OFS_W = 12,
  parameter int REG_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic               winSel,
  input  logic [OFS_W-1:0]   wrOffset,
  input  logic [31:0]        wrData,
  output wr_strobe_t         strobe,
  output logic               keyOn,
  output logic               keyOff,
  output logic [VOICE_W-1:0] keyVoice
);
  localparam logic [REG_W-1:0] OFS_CFG    = REG_W'('h00);
  localparam logic [REG_W-1:0] OFS_ADDRLO = REG_W'('h04);
  localparam logic [REG_W-1:0] OFS_LPSTRT = REG_W'('h08);
  localparam logic [REG_W-1:0] OFS_LPEND  = REG_W'('h0C);
  localparam logic [REG_W-1:0] OFS_PITCH  = REG_W'('h18);
  localparam logic [REG_W-1:0] OFS_PAN    = REG_W'('h24);
  localparam logic [REG_W-1:0] OFS_VOL    = REG_W'('h28);

  logic [REG_W-1:0] regOfs;
  logic [1:0]       keyCmd;

  assign regOfs = wrOffset[REG_W-1:0];
  assign keyCmd = wrData[15:14];

  always_comb begin
    strobe       = '0;
    strobe.voice = {winSel, wrOffset[OFS_W-1:REG_W]};
    strobe.data  = wrData[HALF_W-1:0];
    if (wrEn) begin
      case (regOfs)
        OFS_CFG:    strobe.cfg       = 1'b1;
        OFS_ADDRLO: strobe.addrLo    = 1'b1;
        OFS_LPSTRT: strobe.loopStart = 1'b1;
        OFS_LPEND:  strobe.loopEnd   = 1'b1;
        OFS_PITCH:  strobe.pitch     = 1'b1;
        OFS_PAN:    strobe.pan       = 1'b1;
        OFS_VOL:    strobe.vol       = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keyOn    <= 1'b0;
      keyOff   <= 1'b0;
      keyVoice <= '0;
    end else begin
      keyOn  <= strobe.cfg && (keyCmd == 2'b11);
      keyOff <= strobe.cfg && (keyCmd == 2'b10);
      if (strobe.cfg && keyCmd[1]) keyVoice <= strobe.voice;
    end
  end
endmodule

// File: rtl/voice_reg_dp.sv
module voice_reg_dp
  import voice_reg_pkg::*;
#(
  parameter int NUM_VOICES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  wr_strobe_t         strobe,
  input  logic [VOICE_W-1:0] rdVoice,
  output logic [20:0]        rdStartAddr,
  output logic               rdLoopEn,
  output logic [1:0]         rdFormat,
  output logic [15:0]        rdLoopStart,
  output logic [15:0]        rdLoopEnd,
  output logic [15:0]        rdPitch,
  output logic [4:0]         rdPan,
  output logic [7:0]         rdVolume
);
  logic [4:0]  startHiQ   [NUM_VOICES];
  logic [15:0] startLoQ   [NUM_VOICES];
  logic        loopEnQ    [NUM_VOICES];
  logic [1:0]  fmtQ       [NUM_VOICES];
  logic [15:0] loopStartQ [NUM_VOICES];
  logic [15:0] loopEndQ   [NUM_VOICES];
  logic [15:0] pitchQ     [NUM_VOICES];
  logic [4:0]  panQ       [NUM_VOICES];
  logic [7:0]  volQ       [NUM_VOICES];

  function automatic logic [4:0] foldPan(input logic [4:0] p);
    return p[4] ? p : (5'd15 - p);
  endfunction

  function automatic logic [7:0] taperVol(input logic [7:0] v);
    logic [15:0] prod;
    prod = {8'd0, v} * ({8'd0, v} + 16'd1);
    return prod[15:8];
  endfunction

  function automatic logic [1:0] decodeFmt(input logic [1:0] f);
    return f[1] ? FMT_ADPCM : (f[0] ? FMT_PCM8 : FMT_PCM16);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_VOICES; i++) begin
        startHiQ[i]   <= '0;
        startLoQ[i]   <= '0;
        loopEnQ[i]    <= 1'b0;
        fmtQ[i]       <= '0;
        loopStartQ[i] <= '0;
        loopEndQ[i]   <= '0;
        pitchQ[i]     <= '0;
        panQ[i]       <= '0;
        volQ[i]       <= '0;
      end
    end else begin
      if (strobe.cfg) begin
        startHiQ[strobe.voice] <= strobe.data[4:0];
        loopEnQ[strobe.voice]  <= strobe.data[9];
        fmtQ[strobe.voice]     <= decodeFmt(strobe.data[8:7]);
      end
      if (strobe.addrLo)    startLoQ[strobe.voice]   <= strobe.data;
      if (strobe.loopStart) loopStartQ[strobe.voice] <= strobe.data;
      if (strobe.loopEnd)   loopEndQ[strobe.voice]   <= strobe.data;
      if (strobe.pitch)     pitchQ[strobe.voice]     <= strobe.data;
      if (strobe.pan)       panQ[strobe.voice]       <= foldPan(strobe.data[4:0]);
      if (strobe.vol)       volQ[strobe.voice]       <= taperVol(strobe.data[7:0]);
    end
  end

  assign rdStartAddr = {startHiQ[rdVoice], startLoQ[rdVoice]};
  assign rdLoopEn    = loopEnQ[rdVoice];
  assign rdFormat    = fmtQ[rdVoice];
  assign rdLoopStart = loopStartQ[rdVoice];
  assign rdLoopEnd   = loopEndQ[rdVoice];
  assign rdPitch     = pitchQ[rdVoice];
  assign rdPan       = panQ[rdVoice];
  assign rdVolume    = volQ[rdVoice];
endmodule

// File: rtl/voice_reg_decoder.sv
module voice_reg_decoder
  import voice_reg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic        winSel,
  input  logic [11:0] wrOffset,
  input  logic [31:0] wrData,
  input  logic [5:0]  rdVoice,
  output logic [20:0] rdStartAddr,
  output logic        rdLoopEn,
  output logic [1:0]  rdFormat,
  output logic [15:0] rdLoopStart,
  output logic [15:0] rdLoopEnd,
  output logic [15:0] rdPitch,
  output logic [4:0]  rdPan,
  output logic [7:0]  rdVolume,
  output logic        keyOn,
  output logic        keyOff,
  output logic [5:0]  keyVoice
);
  wr_strobe_t strobe;

  voice_reg_ctrl #(.OFS_W(12), .REG_W(7)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .winSel(winSel),
    .wrOffset(wrOffset), .wrData(wrData), .strobe(strobe),
    .keyOn(keyOn), .keyOff(keyOff), .keyVoice(keyVoice)
  );

  voice_reg_dp #(.NUM_VOICES(64)) i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rdVoice(rdVoice),
    .rdStartAddr(rdStartAddr), .rdLoopEn(rdLoopEn), .rdFormat(rdFormat),
    .rdLoopStart(rdLoopStart), .rdLoopEnd(rdLoopEnd), .rdPitch(rdPitch),
    .rdPan(rdPan), .rdVolume(rdVolume)
  );
endmodule

// File: rtl/voice_reg_checks.sv
module voice_reg_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        wrEn,
  input logic        winSel,
  input logic [11:0] wrOffset,
  input logic [31:0] wrData,
  input logic [5:0]  rdVoice,
  input logic [20:0] rdStartAddr,
  input logic [4:0]  rdPan,
  input logic [7:0]  rdVolume,
  input logic [15:0] rdPitch,
  input logic        keyOn,
  input logic        keyOff,
  input logic [5:0]  keyVoice
);
  logic [4:0] expPan;
  logic       panHit;
  logic       envHit;
  assign expPan = (wrData[4:0] < 5'd16) ? (5'd15 - wrData[4:0]) : wrData[4:0];
  assign panHit = wrEn && wrOffset[6:0] == 7'h24 && {winSel, wrOffset[11:7]} == rdVoice;
  assign envHit = wrEn && (wrOffset[6:0] == 7'h10 || wrOffset[6:0] == 7'h14);

  p_key_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(keyOn && keyOff));

  p_keyon_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    keyOn |-> $past(wrEn && wrOffset[6:0] == 7'h00 && wrData[15:14] == 2'b11));

  p_keyoff_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    keyOff |-> $past(wrEn && wrOffset[6:0] == 7'h00 && wrData[15:14] == 2'b10));

  p_key_voice_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (keyOn || keyOff) |-> keyVoice == $past({winSel, wrOffset[11:7]}));

  p_pan_fold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    panHit ##1 $stable(rdVoice) |-> rdPan == $past(expPan));

  p_env_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    envHit ##1 $stable(rdVoice) |-> $stable(rdStartAddr) && $stable(rdPan)
      && $stable(rdVolume) && $stable(rdPitch) && !keyOn && !keyOff);
endmodule

bind voice_reg_decoder voice_reg_checks i_checks (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .winSel(winSel), .wrOffset(wrOffset),
  .wrData(wrData), .rdVoice(rdVoice), .rdStartAddr(rdStartAddr), .rdPan(rdPan),
  .rdVolume(rdVolume), .rdPitch(rdPitch), .keyOn(keyOn), .keyOff(keyOff),
  .keyVoice(keyVoice)
);

// File: tb/test_voice_reg_decoder.sv
`timescale 1ns/1ps
module test_voice_reg_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic        winSel = 1'b0;
  logic [11:0] wrOffset = '0;
  logic [31:0] wrData = '0;
  logic [5:0]  rdVoice = '0;
  logic [20:0] rdStartAddr;
  logic        rdLoopEn;
  logic [1:0]  rdFormat;
  logic [15:0] rdLoopStart, rdLoopEnd, rdPitch;
  logic [4:0]  rdPan;
  logic [7:0]  rdVolume;
  logic        keyOn, keyOff;
  logic [5:0]  keyVoice;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  voice_reg_decoder i_voice_reg_decoder (.*);

  always #10 clk = ~clk;

  // entry: win(1) offset(12) data(32) field(3) expected(21)
  // field: 0 start addr, 1 loop en, 2 format, 3 loop start, 4 loop end, 5 pitch, 6 pan, 7 volume
  localparam int NV = 18;
  localparam logic [68:0] VEC [NV] = '{
    {1'b0, 12'h004, 32'hABCD1234, 3'd0, 21'h001234},  // R2 R3 low address
    {1'b0, 12'h000, 32'h00000215, 3'd0, 21'h151234},  // R3 high bits keep low
    {1'b0, 12'h010, 32'hFFFFFFFF, 3'd1, 21'd1},       // R9 envelope ignored, loop kept
    {1'b0, 12'h014, 32'hFFFFFFFF, 3'd0, 21'h151234},  // R9
    {1'b0, 12'h080, 32'h00000080, 3'd2, 21'd1},       // R4 8-bit
    {1'b0, 12'h080, 32'h00000180, 3'd2, 21'd2},       // R4 field 3
    {1'b0, 12'h080, 32'h00000100, 3'd2, 21'd2},       // R4 field 2
    {1'b1, 12'h088, 32'h12348765, 3'd3, 21'h8765},    // R1 R6 voice 33
    {1'b1, 12'hF8C, 32'h00004321, 3'd4, 21'h4321},    // R1 R6 voice 63
    {1'b0, 12'hF98, 32'hFFFF3FFF, 3'd5, 21'h3FFF},    // R6 voice 31
    {1'b0, 12'h124, 32'h00000003, 3'd6, 21'd12},      // R7
    {1'b0, 12'h124, 32'h00000015, 3'd6, 21'd21},      // R7
    {1'b0, 12'h124, 32'h0000000F, 3'd6, 21'd0},       // R7 edge
    {1'b0, 12'h124, 32'hFFFF00E5, 3'd6, 21'd10},      // R7 R2
    {1'b0, 12'h128, 32'h000000FF, 3'd7, 21'd255},     // R8 top
    {1'b0, 12'h128, 32'h00000080, 3'd7, 21'd64},      // R8 mid
    {1'b0, 12'h128, 32'h00001234, 3'd7, 21'd10},      // R8 low byte only
    {1'b0, 12'h12A, 32'h00000000, 3'd7, 21'd10}       // R9 undefined offset
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic w, input logic [11:0] ofs, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; winSel = w; wrOffset = ofs; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  function automatic logic [31:0] readField(input logic [2:0] f);
    case (f)
      3'd0: return 32'(rdStartAddr);
      3'd1: return 32'(rdLoopEn);
      3'd2: return 32'(rdFormat);
      3'd3: return 32'(rdLoopStart);
      3'd4: return 32'(rdLoopEnd);
      3'd5: return 32'(rdPitch);
      3'd6: return 32'(rdPan);
      default: return 32'(rdVolume);
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rdVoice = 6'd5;
    #1;
    check("R10 reset start", 32'(rdStartAddr), 0);
    check("R10 reset volume", 32'(rdVolume), 0);
    check("R10 reset pan", 32'(rdPan), 0);
    check("R10 reset keys", {keyOn, keyOff}, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic        w;
      logic [11:0] o;
      logic [31:0] d;
      logic [2:0]  f;
      logic [20:0] e;
      {w, o, d, f, e} = VEC[i];
      rdVoice = {w, o[11:7]};
      doWrite(w, o, d);
      check($sformatf("R11 vector %0d", i), readField(f), 32'(e));
      check($sformatf("R9 no pulse vector %0d", i), {keyOn, keyOff}, 0);
    end

    // R5 key-on combined with config update on voice 40 (window 1, slot 8)
    rdVoice = 6'd40;
    doWrite(1'b1, 12'h404, 32'h0000BEEF);
    doWrite(1'b1, 12'h400, 32'h0000C203);
    check("R5 keyOn pulse", 32'(keyOn), 1);
    check("R5 keyOn voice", 32'(keyVoice), 40);
    check("R3 combined start", 32'(rdStartAddr), 32'h03BEEF);
    check("R3 combined loop", 32'(rdLoopEn), 1);
    @(posedge clk); #1;
    check("R5 keyOn one cycle", 32'(keyOn), 0);

    // R5 key-off on voice 7
    doWrite(1'b0, 12'h380, 32'h00008000);
    check("R5 keyOff pulse", {keyOn, keyOff}, 1);
    check("R5 keyOff voice", 32'(keyVoice), 7);
    @(posedge clk); #1;
    check("R5 keyOff one cycle", 32'(keyOff), 0);

    // R5 commands 0 and 1 and R2 upper bits cause no pulse
    doWrite(1'b0, 12'h380, 32'h00004000);
    check("R5 command 1 no pulse", {keyOn, keyOff}, 0);
    doWrite(1'b0, 12'h380, 32'hC0000000);
    check("R2 upper bits no pulse", {keyOn, keyOff}, 0);

    // R9 offsets 0x1C and 0x20 ignored on voice 31
    rdVoice = 6'd31;
    doWrite(1'b0, 12'hF9C, 32'h0000FFFF);
    doWrite(1'b0, 12'hFA0, 32'h0000FFFF);
    check("R9 pitch kept", 32'(rdPitch), 32'h3FFF);
    check("R9 pan kept", 32'(rdPan), 0);

    // R1 window isolation: voice 1 untouched by voice 33 write
    rdVoice = 6'd1;
    #1;
    check("R1 voice 1 loop start", 32'(rdLoopStart), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule